// File: doc/BRIEF.md
# Fault and Noise Injecting Logic Gate Model

This block stands in for a single two-input logic gate inside a hardware emulation of an unreliable circuit. Signal levels travel as unsigned fixed-point numbers: the all-ones code means logic 1 and zero means logic 0. Each evaluation passes the two input levels and the gate result through three fault sites, one per input and one on the output. Each site either lets the level through or corrupts it with a randomly chosen fault. A bounded random offset is then added to the output level, and the result is rounded to a logic value.

An evaluation starts with a one-cycle `start` pulse. All operands are captured at that edge. A small state machine then walks four named states. From IDLE it moves to SITE_A when `start` is seen. SITE_A applies the fault site to input A and moves to SITE_B. SITE_B does the same for input B and moves to SITE_Y. SITE_Y applies the gate function and the output fault site, then moves to NOISE. NOISE adds the offset, registers the outputs, raises `done` and returns to IDLE. A single fault-site unit is shared by the three site states. A 32-bit LFSR takes one step in each non-idle state and supplies all random draws. The LFSR can be reseeded so that runs repeat exactly.

Parameters: `W` is the signal width (default 8) and `PW` is the fault-draw width (default 8). The LFSR bit slicing requires `PW + 16 + W <= 32`.

Top module: `gate_fault_injector`

## Requirements
- R1: After reset, `out_level` is 0, `out_logic` is 0 and `done` is 0.
- R2: `start` is sampled only in IDLE, and all operands are captured at that edge. `done` is high for exactly one cycle, after the fourth clock edge that follows the capturing edge. `out_level` and `out_logic` change only at that edge. A `start` seen while an evaluation is running is ignored.
- R3: The `gate_sel` codes are 0 AND, 1 NAND, 2 OR, 3 NOR, 4 NOT of A, 5 constant 1, and 6 or 7 constant 0. A fault-free, noise-free result is full scale for logic 1 and 0 for logic 0.
- R4: An input level at or above 2^(W-1) reads as logic 1, and any level below it reads as logic 0.
- R5: A site faults when its PW-bit draw, taken as unsigned, is below `fault_thresh`. A threshold of 0 never faults, and a threshold of 2^PW always faults. With any other value the fault rate is `fault_thresh`/2^PW.
- R6: A fault takes one of three kinds with equal probability (bias below 2^-14): stuck-at, floating or half-random. A stuck-at fault forces the level to 0 or to full scale, chosen by one random bit.
- R7: A floating fault replaces the level with a uniform random W-bit value. A half-random fault keeps one logic value and randomises the other. A random bit picks which one is kept: either a logic-1 level becomes full scale and a logic-0 level becomes random, or a logic-0 level becomes 0 and a logic-1 level becomes random.
- R8: When `protect` is 1, no site faults at any threshold, but noise is still added.
- R9: The noise amplitude is floor(p*(2^W-1)/100), where p is `noise_pct` with values above 100 treated as 100. The offset is drawn uniformly from [-amplitude, +amplitude]. With p equal to 0 the output level equals the faulted gate output.
- R10: A noisy level that falls below 0 or rises above full scale saturates at 0 or at full scale. It never wraps.
- R11: `out_logic` is 1 exactly when `out_level` is at or above 2^(W-1).
- R12: The LFSR is a 32-bit Galois generator that shifts right and XORs the mask 0x80200003 into the state when the bit shifted out is 1. It steps once in each non-idle state. `seed_load` loads `seed`, and a zero seed is replaced by 1. Equal seeds with equal operands give equal output sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load `seed` into the LFSR |
| seed | input | 32 | LFSR seed value |
| start | input | 1 | Begin one evaluation (sampled in IDLE) |
| gate_sel | input | 3 | Gate function code |
| in_a | input | W | Input A level |
| in_b | input | W | Input B level |
| fault_thresh | input | PW+1 | Per-site fault threshold |
| noise_pct | input | 7 | Noise range in percent of full scale |
| protect | input | 1 | Suppress all faults for this gate |
| out_level | output | W | Faulted, noisy output level |
| out_logic | output | 1 | Output level rounded to a logic value |
| done | output | 1 | One-cycle pulse when the outputs are updated |

## Verification
The cycle-level assertions hold the state sequence and the `done` pulse to the NOISE state, keep `out_level` steady outside that state, and tie `out_logic` to the rounding threshold. They also check that a protected site passes its input unchanged, that a zero threshold leaves the output site untouched, that a zero noise range adds nothing, and that the LFSR never reaches zero. The fault-type mix, the fault rate at a fractional threshold, the noise bounds and saturation, and seed repeatability are statistical or span several evaluations, so only the bench scenarios can show them, by counting results over hundreds of evaluations.

// File: rtl/gfi_pkg.sv
package gfi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SITE_A,
        ST_SITE_B,
        ST_SITE_Y,
        ST_NOISE
    } gfi_state_e;

    typedef enum logic [1:0] {
        FK_STUCK   = 2'd0,
        FK_FLOAT   = 2'd1,
        FK_PARTIAL = 2'd2
    } gfi_fault_e;

    typedef enum logic [2:0] {
        GF_AND   = 3'd0,
        GF_NAND  = 3'd1,
        GF_OR    = 3'd2,
        GF_NOR   = 3'd3,
        GF_NOT   = 3'd4,
        GF_ONE   = 3'd5,
        GF_ZERO  = 3'd6,
        GF_ZERO2 = 3'd7
    } gfi_gate_e;

    localparam int unsigned LFSR_W    = 32;
    localparam logic [31:0] LFSR_MASK = 32'h8020_0003;

endpackage

// File: rtl/gfi_lfsr.sv
module gfi_lfsr
    import gfi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              step,
    output logic [LFSR_W-1:0] state
);

    logic [LFSR_W-1:0] nxt;

    always_comb begin
        nxt = state >> 1;
        if (state[0]) begin
            nxt = nxt ^ LFSR_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= {{(LFSR_W-1){1'b0}}, 1'b1};
        end else if (load) begin
            state <= (seed == '0) ? {{(LFSR_W-1){1'b0}}, 1'b1} : seed;
        end else if (step) begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/gfi_fault_site.sv
module gfi_fault_site
    import gfi_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned PW = 8
) (
    input  logic [W-1:0]      lvl_in,
    input  logic [LFSR_W-1:0] draw,
    input  logic [PW:0]       thresh,
    input  logic              protect,
    output logic [W-1:0]      lvl_out
);

    localparam int unsigned KW = 15;
    localparam int unsigned SB = PW + KW;
    localparam logic [W-1:0] FULL = '1;
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic           fire;
    logic [KW-1:0]  kind_draw;
    logic [1:0]     kind_raw;
    gfi_fault_e     kind;
    logic           sel;
    logic [W-1:0]   rnd;
    logic           is_one;

    assign fire      = !protect && ({1'b0, draw[PW-1:0]} < thresh);
    assign kind_draw = draw[PW +: KW];
    assign kind_raw  = 2'(((KW+2)'(kind_draw) * (KW+2)'(3)) >> KW);
    assign kind      = gfi_fault_e'(kind_raw);
    assign sel       = draw[SB];
    assign rnd       = draw[LFSR_W-1 -: W];
    assign is_one    = (lvl_in >= HALF);

    always_comb begin
        lvl_out = lvl_in;
        if (fire) begin
            unique case (kind)
                FK_STUCK:   lvl_out = sel ? FULL : '0;
                FK_FLOAT:   lvl_out = rnd;
                FK_PARTIAL: begin
                    if (sel) lvl_out = is_one ? FULL : rnd;
                    else     lvl_out = is_one ? rnd : '0;
                end
                default:    lvl_out = lvl_in;
            endcase
        end
    end

endmodule

// File: rtl/gfi_gate_eval.sv
module gfi_gate_eval
    import gfi_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] lvl_a,
    input  logic [W-1:0] lvl_b,
    input  gfi_gate_e    func,
    output logic [W-1:0] lvl_y
);

    localparam logic [W-1:0] FULL = '1;
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic la, lb, ly;

    assign la = (lvl_a >= HALF);
    assign lb = (lvl_b >= HALF);

    always_comb begin
        unique case (func)
            GF_AND:   ly = la & lb;
            GF_NAND:  ly = !(la & lb);
            GF_OR:    ly = la | lb;
            GF_NOR:   ly = !(la | lb);
            GF_NOT:   ly = !la;
            GF_ONE:   ly = 1'b1;
            GF_ZERO:  ly = 1'b0;
            GF_ZERO2: ly = 1'b0;
            default:  ly = 1'b0;
        endcase
    end

    assign lvl_y = ly ? FULL : '0;

endmodule

// File: rtl/gfi_noise_add.sv
module gfi_noise_add #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] lvl_in,
    input  logic [15:0]  draw,
    input  logic [6:0]   pct,
    output logic [W-1:0] lvl_out
);

    localparam int unsigned SW = W + 18;
    localparam int unsigned FS = (1 << W) - 1;

    logic [6:0]    pct_cl;
    logic [W:0]    amp;
    logic [W+1:0]  span;
    logic [W+1:0]  pick;
    logic [SW-1:0] sum;

    assign pct_cl = (pct > 7'd100) ? 7'd100 : pct;
    assign amp    = (W+1)'((SW'(pct_cl) * SW'(FS)) / SW'(100));
    assign span   = (W+2)'({amp, 1'b1});
    assign pick   = (W+2)'((SW'(span) * SW'(draw)) >> 16);
    assign sum    = SW'(lvl_in) + SW'(pick) - SW'(amp);

    always_comb begin
        if (sum[SW-1]) begin
            lvl_out = '0;
        end else if (sum > SW'(FS)) begin
            lvl_out = '1;
        end else begin
            lvl_out = W'(sum);
        end
    end

endmodule

// File: rtl/gate_fault_injector.sv
module gate_fault_injector
    import gfi_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned PW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic [31:0]       seed,
    input  logic              start,
    input  logic [2:0]        gate_sel,
    input  logic [W-1:0]      in_a,
    input  logic [W-1:0]      in_b,
    input  logic [PW:0]       fault_thresh,
    input  logic [6:0]        noise_pct,
    input  logic              protect,
    output logic [W-1:0]      out_level,
    output logic              out_logic,
    output logic              done
);

    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    gfi_state_e        state, nxt_state;
    logic [LFSR_W-1:0] lfsr;
    logic [W-1:0]      a_c, b_c, a_f, b_f, y_f;
    gfi_gate_e         gate_c;
    logic [PW:0]       thr_c;
    logic [6:0]        pct_c;
    logic              prot_c;
    logic [W-1:0]      gate_lvl, site_in, site_out, noisy;

    gfi_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seed_load),
        .seed  (seed),
        .step  (state != ST_IDLE),
        .state (lfsr)
    );

    gfi_gate_eval #(.W(W)) u_gate (
        .lvl_a (a_f),
        .lvl_b (b_f),
        .func  (gate_c),
        .lvl_y (gate_lvl)
    );

    always_comb begin
        unique case (state)
            ST_SITE_A: site_in = a_c;
            ST_SITE_B: site_in = b_c;
            default:   site_in = gate_lvl;
        endcase
    end

    gfi_fault_site #(.W(W), .PW(PW)) u_site (
        .lvl_in  (site_in),
        .draw    (lfsr),
        .thresh  (thr_c),
        .protect (prot_c),
        .lvl_out (site_out)
    );

    gfi_noise_add #(.W(W)) u_noise (
        .lvl_in  (y_f),
        .draw    (lfsr[15:0]),
        .pct     (pct_c),
        .lvl_out (noisy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:   nxt_state = start ? ST_SITE_A : ST_IDLE;
            ST_SITE_A: nxt_state = ST_SITE_B;
            ST_SITE_B: nxt_state = ST_SITE_Y;
            ST_SITE_Y: nxt_state = ST_NOISE;
            ST_NOISE:  nxt_state = ST_IDLE;
            default:   nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_c       <= '0;
            b_c       <= '0;
            a_f       <= '0;
            b_f       <= '0;
            y_f       <= '0;
            gate_c    <= GF_ZERO;
            thr_c     <= '0;
            pct_c     <= '0;
            prot_c    <= 1'b0;
            out_level <= '0;
            out_logic <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_c    <= in_a;
                        b_c    <= in_b;
                        gate_c <= gfi_gate_e'(gate_sel);
                        thr_c  <= fault_thresh;
                        pct_c  <= noise_pct;
                        prot_c <= protect;
                    end
                end
                ST_SITE_A: a_f <= site_out;
                ST_SITE_B: b_f <= site_out;
                ST_SITE_Y: y_f <= site_out;
                ST_NOISE: begin
                    out_level <= noisy;
                    out_logic <= (noisy >= HALF);
                    done      <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/gfi_checker.sv
module gfi_checker
    import gfi_pkg::*;
#(
    parameter int unsigned W  = 8,
    parameter int unsigned PW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input gfi_state_e        state,
    input logic [LFSR_W-1:0] lfsr,
    input logic [W-1:0]      a_c,
    input logic [W-1:0]      a_f,
    input logic [W-1:0]      y_f,
    input logic [W-1:0]      gate_lvl,
    input logic              prot_c,
    input logic [PW:0]       thr_c,
    input logic [6:0]        pct_c,
    input logic [W-1:0]      out_level,
    input logic              out_logic,
    input logic              done
);

    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    p_done_after_noise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state == ST_NOISE));

    p_order_a_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SITE_A) |=> (state == ST_SITE_B));

    p_order_b_y_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SITE_B) |=> (state == ST_SITE_Y));

    p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_NOISE) |=> $stable(out_level));

    p_zero_thresh_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SITE_Y && thr_c == '0) |=> (y_f == $past(gate_lvl)));

    p_protect_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SITE_A && prot_c) |=> (a_f == $past(a_c)));

    p_no_noise_exact_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NOISE && pct_c == 7'd0) |=> (out_level == $past(y_f)));

    p_round_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_logic == (out_level >= HALF));

    p_lfsr_live_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);

endmodule

bind gate_fault_injector gfi_checker #(.W(W), .PW(PW)) u_gfi_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .lfsr      (lfsr),
    .a_c       (a_c),
    .a_f       (a_f),
    .y_f       (y_f),
    .gate_lvl  (gate_lvl),
    .prot_c    (prot_c),
    .thr_c     (thr_c),
    .pct_c     (pct_c),
    .out_level (out_level),
    .out_logic (out_logic),
    .done      (done)
);

// File: tb/gate_fault_injector_test.sv
module gate_fault_injector_test;

    localparam int CLK_PERIOD = 10;
    localparam int FS = 255;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [31:0] seed = '0;
    logic        start = 1'b0;
    logic [2:0]  gate_sel = '0;
    logic [7:0]  in_a = '0;
    logic [7:0]  in_b = '0;
    logic [8:0]  fault_thresh = '0;
    logic [6:0]  noise_pct = '0;
    logic        protect = 1'b0;
    logic [7:0]  out_level;
    logic        out_logic;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gate_fault_injector uut (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
        .start(start), .gate_sel(gate_sel), .in_a(in_a), .in_b(in_b),
        .fault_thresh(fault_thresh), .noise_pct(noise_pct), .protect(protect),
        .out_level(out_level), .out_logic(out_logic), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input longint act, input longint lo, input longint hi);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    function automatic bit ref_gate(input int g, input bit x, input bit y);
        case (g)
            0: return x & y;
            1: return !(x & y);
            2: return x | y;
            3: return !(x | y);
            4: return !x;
            5: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_eval(input int g, input int a, input int b, input int thr,
                            input int pct, input bit prot,
                            output int lvl, output bit lg, output int lat);
        @(negedge clk);
        gate_sel = 3'(g); in_a = 8'(a); in_b = 8'(b);
        fault_thresh = 9'(thr); noise_pct = 7'(pct); protect = prot;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 12) begin
            @(negedge clk);
            lat++;
        end
        lvl = out_level;
        lg  = out_logic;
    endtask

    task automatic load_seed(input logic [31:0] s);
        @(negedge clk);
        seed = s; seed_load = 1'b1;
        @(negedge clk);
        seed_load = 1'b0;
    endtask

    task automatic t_reset;
        chk(out_level == 0, "R1 level after reset", out_level, 0);
        chk(out_logic == 0, "R1 logic after reset", out_logic, 0);
        chk(done == 0, "R1 done after reset", done, 0);
    endtask

    task automatic t_timing;
        int lvl, lat; bit lg;
        run_eval(0, FS, FS, 0, 0, 0, lvl, lg, lat);
        chk(lat == 4, "R2 done latency", lat, 4);
        chk(lvl == FS, "R2 result", lvl, FS);
        @(negedge clk);
        chk(done == 0, "R2 done single cycle", done, 0);
    endtask

    task automatic t_capture_busy;
        int pulses = 0;
        @(negedge clk);
        gate_sel = 3'd0; in_a = 8'(FS); in_b = 8'(FS);
        fault_thresh = 0; noise_pct = 0; protect = 0; start = 1'b1;
        @(negedge clk);
        gate_sel = 3'd6; in_a = 0; in_b = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 14; k++) begin
            if (done) begin
                pulses++;
                chk(out_level == FS, "R2 operands captured at start", out_level, FS);
            end
            @(negedge clk);
        end
        chk(pulses == 1, "R2 start while busy ignored", pulses, 1);
    endtask

    task automatic t_truth(input bit prot, input int thr, input string tag);
        int lvl, lat; bit lg, e;
        for (int g = 0; g < 8; g++) begin
            for (int c = 0; c < 4; c++) begin
                run_eval(g, c[0] ? FS : 0, c[1] ? FS : 0, thr, 0, prot, lvl, lg, lat);
                e = ref_gate(g, c[0], c[1]);
                chk(lvl == (e ? FS : 0), tag, lvl, e ? FS : 0);
                chk(lg == e, tag, lg, e);
            end
        end
    endtask

    task automatic t_threshold;
        int lvl, lat; bit lg;
        run_eval(0, 128, 127, 0, 0, 0, lvl, lg, lat);
        chk(lvl == 0, "R4 AND 128,127", lvl, 0);
        run_eval(0, 128, 200, 0, 0, 0, lvl, lg, lat);
        chk(lvl == FS, "R4 AND 128,200", lvl, FS);
        run_eval(2, 127, 0, 0, 0, 0, lvl, lg, lat);
        chk(lvl == 0, "R4 OR 127,0", lvl, 0);
        run_eval(4, 127, 0, 0, 0, 0, lvl, lg, lat);
        chk(lvl == FS, "R4 NOT 127", lvl, FS);
        run_eval(4, 128, 0, 0, 0, 0, lvl, lg, lat);
        chk(lvl == 0, "R4 NOT 128", lvl, 0);
    endtask

    task automatic t_fault_mix;
        int lvl, lat, zeros = 0, fulls = 0, mids = 0; bit lg;
        for (int k = 0; k < 600; k++) begin
            run_eval(6, 0, 0, 256, 0, 0, lvl, lg, lat);
            if (lvl == 0) zeros++;
            else if (lvl == FS) fulls++;
            else mids++;
        end
        chk_rng("R6 R7 share at zero", zeros, 132, 276);
        chk_rng("R6 stuck at full scale", fulls, 48, 156);
        chk_rng("R7 random levels", mids, 180, 420);
    endtask

    task automatic t_fault_rate;
        int lvl, lat, hit = 0; bit lg;
        for (int k = 0; k < 600; k++) begin
            run_eval(6, 0, 0, 64, 0, 0, lvl, lg, lat);
            if (lvl != 0) hit++;
        end
        chk_rng("R5 quarter threshold rate", hit, 50, 160);
    endtask

    task automatic t_noise_sat;
        int lvl, lat, sat = 0, mn = FS; bit lg;
        for (int k = 0; k < 200; k++) begin
            run_eval(5, 0, 0, 0, 20, 0, lvl, lg, lat);
            if (lvl == FS) sat++;
            if (lvl < mn) mn = lvl;
            if (lvl < 204) chk(0, "R9 noise lower bound", lvl, 204);
        end
        chk_rng("R10 saturation at full scale", sat, 70, 130);
        chk_rng("R9 noise reaches below", mn, 204, 215);
    endtask

    task automatic t_protect_noise;
        int lvl, lat, nz = 0; bit lg;
        for (int k = 0; k < 200; k++) begin
            run_eval(6, 0, 0, 256, 20, 1, lvl, lg, lat);
            if (lvl != 0) nz++;
            if (lvl > 51) chk(0, "R8 protected level bound", lvl, 51);
        end
        chk_rng("R8 noise kept under protect", nz, 60, 140);
    endtask

    task automatic t_round;
        int lvl, lat, hi = 0; bit lg;
        for (int k = 0; k < 200; k++) begin
            run_eval(6, 0, 0, 0, 120, 0, lvl, lg, lat);
            if (lg != (lvl >= 128)) chk(0, "R11 rounding", lg, lvl >= 128);
            if (lg) hi++;
        end
        chk_rng("R11 rounding seen both ways", hi, 1, 199);
    endtask

    task automatic t_seed;
        int r1[10]; int lvl, lat, nz = 0; bit lg;
        load_seed(32'hACE1_1357);
        for (int k = 0; k < 10; k++) begin
            run_eval(6, 0, 0, 256, 30, 0, lvl, lg, lat);
            r1[k] = lvl;
        end
        load_seed(32'hACE1_1357);
        for (int k = 0; k < 10; k++) begin
            run_eval(6, 0, 0, 256, 30, 0, lvl, lg, lat);
            chk(lvl == r1[k], "R12 seed repeat", lvl, r1[k]);
        end
        load_seed(32'h0);
        for (int k = 0; k < 50; k++) begin
            run_eval(6, 0, 0, 256, 0, 0, lvl, lg, lat);
            if (lvl != 0) nz++;
        end
        chk_rng("R12 zero seed replaced", nz, 1, 50);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        load_seed(32'h1234_5678);
        t_timing();
        t_capture_busy();
        t_truth(1'b0, 0, "R3 truth table");
        t_truth(1'b1, 256, "R8 protect exact");
        t_threshold();
        t_fault_mix();
        t_fault_rate();
        t_noise_sat();
        t_protect_noise();
        t_round();
        t_seed();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule